// File: doc/BRIEF.md
# SDRAM Mode-Register Set Sequencer

This block sits between a CPU-side bus and the command pins shared by two synchronous DRAM chip-select areas. It watches CPU writes for a byte-size store that lands in one of two reserved 4 KB address windows, one per area. A hit starts a short command sequence on the addressed area only. The block issues precharge-all first, then a programmable number of idle cycles, and then a mode-register-set command. The mode value it places on the DRAM address pins comes from the low twelve bits of the write address.

The block has no data input. The value written is irrelevant, so the CPU data lines are not wired to it. Where the mode fields sit inside the offset depends on the bus width of the part, which is chosen by a parameter. On a 32-bit bus every field sits one pin higher than on a 16-bit bus. An offset that does not decode to a supported mode is refused and raises a one-cycle error pulse. Software must set up the DRAM timing registers elsewhere before it writes to a window.

Top module: `sdram_mrs_seq`

## Requirements
- R1: A byte write to 0xFFFFD000 + X starts a sequence that asserts only `sd_cs2_n`. A byte write to 0xFFFFE000 + X starts one that asserts only `sd_cs3_n`. The other chip select stays high for the whole sequence.
- R2: The mode offsets for `BUS32=1` are 0x840, 0x880 and 0x8C0 (CAS latency 1, 2, 3). In the MRS cycle, pins A15..A9 = 0000100, A8..A6 = latency, A5 = 0 (sequential), A4..A2 = 000 (burst length 1) and A1..A0 = 0.
- R3: The mode offsets for `BUS32=0` are 0x420, 0x440 and 0x460. In the MRS cycle, A14..A8 = 0000100, A7..A5 = latency, A4 = 0, A3..A1 = 000, and A15 and A0 are 0.
- R4: The command order is fixed. PALL ({cs,ras,cas,we} = 0010, A10 high) comes in the cycle after the accepted write. `GAP_NOPS` NOP cycles (0111) follow, then MRS (0000). The sequence ends with the command pins idle.
- R5: A window write whose size code is not byte (`cpu_size` != 2'b00) is ignored. So is a byte write outside both windows. Neither starts a command nor raises the error flag.
- R6: A byte write in a window whose offset has a CAS latency of 0 or 4..7, a non-zero burst length, the interleaved burst bit set, any other field value, or a set bit below the field does not start a sequence. In the next cycle `mrs_err` pulses high for exactly one cycle.
- R7: `mrs_busy` is high from the cycle after the accepted write up to and including the cycle after MRS. `mrs_done` is high for exactly that last cycle.
- R8: A byte write to a window while `mrs_busy` is high drives `cpu_wait` high in that cycle and is not taken. The held request is taken in the first cycle with `mrs_busy` low.
- R9: Out of reset and whenever no sequence runs, both chip selects and RAS/CAS/WE are high, `sd_addr` is 0, and `mrs_busy`, `mrs_done`, `mrs_err` and `cpu_wait` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, held while `cpu_wait` is high |
| cpu_addr | input | ADDR_W | CPU write address |
| cpu_size | input | 2 | Access size: 00 byte, 01 word, 10 long |
| cpu_wait | output | 1 | Stall for a window write that arrives while busy |
| mrs_busy | output | 1 | A mode sequence is in progress |
| mrs_done | output | 1 | One-cycle pulse after MRS |
| mrs_err | output | 1 | One-cycle pulse for an unsupported mode offset |
| sd_cs2_n | output | 1 | Chip select, area 2, active low |
| sd_cs3_n | output | 1 | Chip select, area 3, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 16 | DRAM address pins A15..A0 |

## Verification
The two functions that can meet in one cycle are a running command sequence and the arrival of a new window write. The test issues a first mode write to area 2. It then holds a second write, aimed at area 3 with a different latency, from the PALL cycle onward. It checks that `cpu_wait` stays high through the NOP, MRS and done cycles, and that the first sequence still places its own latency on the pins. The second sequence must start exactly one cycle after `mrs_busy` falls and must drive only the area 3 select.

// File: rtl/sdram_mrs_pkg.sv
package sdram_mrs_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam int OFS_W     = 12;
  localparam int PIN_W     = 16;
  localparam int NUM_AREAS = 2;
  localparam int FIELD_W   = 14;

  localparam logic [1:0] SIZE_BYTE  = 2'b00;
  localparam logic [6:0] OPMODE_BRSW = 7'b0000100;

  localparam logic [2:0] RCW_PALL = 3'b010;
  localparam logic [2:0] RCW_MRS  = 3'b000;
  localparam logic [2:0] RCW_NOP  = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PALL = 3'd1,
    ST_GAP  = 3'd2,
    ST_MRS  = 3'd3,
    ST_DONE = 3'd4
  } seq_state_t;

  typedef enum logic {
    AREA_2 = 1'b0,
    AREA_3 = 1'b1
  } area_t;

  // Mode word as it appears on the pins for a given latency and bus width.
  function automatic logic [PIN_W-1:0] pack_mode(input logic [2:0] cl, input logic bus32);
    logic [FIELD_W-1:0] f;
    f = {OPMODE_BRSW, cl, 1'b0, 3'b000};
    return bus32 ? {f, 2'b00} : {1'b0, f, 1'b0};
  endfunction

  // Latency field position inside the window offset.
  function automatic logic [2:0] extract_cl(input logic [OFS_W-1:0] ofs, input logic bus32);
    return bus32 ? ofs[8:6] : ofs[7:5];
  endfunction

  // Offset is legal only if it equals the packed word of a supported latency.
  function automatic logic mode_valid(input logic [OFS_W-1:0] ofs, input logic bus32);
    logic [2:0] cl;
    logic       cl_ok;
    cl    = extract_cl(ofs, bus32);
    cl_ok = (cl >= 3'd1) && (cl <= 3'd3);
    return cl_ok && ({{(PIN_W-OFS_W){1'b0}}, ofs} == pack_mode(cl, bus32));
  endfunction

endpackage

// File: rtl/mrs_win_decode.sv
module mrs_win_decode
  import sdram_mrs_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] AREA2_BASE = 32'hFFFF_D000,
  parameter logic [ADDR_W-1:0] AREA3_BASE = 32'hFFFF_E000,
  parameter bit              BUS32      = 1'b1
) (
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  output logic              win_hit,
  output area_t             win_area,
  output logic [2:0]        win_cl,
  output logic              win_ok
);
  timeunit 1ns; timeprecision 1ps;

  localparam int TAG_W = ADDR_W - OFS_W;

  logic [TAG_W-1:0] tag;
  logic [OFS_W-1:0] ofs;
  logic             hit2;
  logic             hit3;

  assign tag  = cpu_addr[ADDR_W-1:OFS_W];
  assign ofs  = cpu_addr[OFS_W-1:0];
  assign hit2 = (tag == AREA2_BASE[ADDR_W-1:OFS_W]);
  assign hit3 = (tag == AREA3_BASE[ADDR_W-1:OFS_W]);

  assign win_hit  = cpu_wr && (cpu_size == SIZE_BYTE) && (hit2 || hit3);
  assign win_area = hit3 ? AREA_3 : AREA_2;
  assign win_cl   = extract_cl(ofs, BUS32);
  assign win_ok   = mode_valid(ofs, BUS32);

endmodule

// File: rtl/mrs_pin_map.sv
module mrs_pin_map
  import sdram_mrs_pkg::*;
#(
  parameter bit BUS32    = 1'b1,
  parameter int PALL_PIN = 10
) (
  input  logic [2:0]       cl,
  output logic [PIN_W-1:0] mrs_pins,
  output logic [PIN_W-1:0] pall_pins
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [PIN_W-1:0] PALL_WORD = PIN_W'(1) << PALL_PIN;

  assign mrs_pins  = pack_mode(cl, BUS32);
  assign pall_pins = PALL_WORD;

endmodule

// File: rtl/mrs_cmd_fsm.sv
module mrs_cmd_fsm
  import sdram_mrs_pkg::*;
#(
  parameter int GAP_NOPS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  area_t      start_area,
  input  logic [2:0] start_cl,
  output seq_state_t state_q,
  output area_t      area_q,
  output logic [2:0] cl_q,
  output logic       seq_busy,
  output logic       seq_done
);
  timeunit 1ns; timeprecision 1ps;

  localparam int             GAP_W    = (GAP_NOPS > 1) ? $clog2(GAP_NOPS) : 1;
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_NOPS - 1);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      area_q  <= AREA_2;
      cl_q    <= 3'd0;
      gap_cnt <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_PALL;
          area_q  <= start_area;
          cl_q    <= start_cl;
        end
        ST_PALL: begin
          gap_cnt <= '0;
          state_q <= ST_GAP;
        end
        ST_GAP: begin
          if (gap_cnt == GAP_LAST) state_q <= ST_MRS;
          else                     gap_cnt <= gap_cnt + 1'b1;
        end
        ST_MRS:  state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign seq_busy = (state_q != ST_IDLE);
  assign seq_done = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_mrs_seq.sv
module sdram_mrs_seq
  import sdram_mrs_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] AREA2_BASE = 32'hFFFF_D000,
  parameter logic [ADDR_W-1:0] AREA3_BASE = 32'hFFFF_E000,
  parameter bit              BUS32      = 1'b1,
  parameter int              GAP_NOPS   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  output logic              cpu_wait,
  output logic              mrs_busy,
  output logic              mrs_done,
  output logic              mrs_err,
  output logic              sd_cs2_n,
  output logic              sd_cs3_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [PIN_W-1:0]  sd_addr
);
  timeunit 1ns; timeprecision 1ps;

  logic       win_hit;
  area_t      win_area;
  logic [2:0] win_cl;
  logic       win_ok;

  seq_state_t state_q;
  area_t      area_q;
  logic [2:0] cl_q;
  logic       seq_busy;
  logic       seq_done;

  // Named events, visible to the bound checker.
  logic seq_accept;
  logic err_event;
  logic err_q;
  logic drive_cmd;

  logic [PIN_W-1:0]     mrs_pins;
  logic [PIN_W-1:0]     pall_pins;
  logic [2:0]           rcw;
  logic [PIN_W-1:0]     pins;
  logic [NUM_AREAS-1:0] cs_n_vec;

  mrs_win_decode #(
    .ADDR_W    (ADDR_W),
    .AREA2_BASE(AREA2_BASE),
    .AREA3_BASE(AREA3_BASE),
    .BUS32     (BUS32)
  ) u_dec (
    .cpu_wr  (cpu_wr),
    .cpu_addr(cpu_addr),
    .cpu_size(cpu_size),
    .win_hit (win_hit),
    .win_area(win_area),
    .win_cl  (win_cl),
    .win_ok  (win_ok)
  );

  assign seq_accept = win_hit && win_ok && !seq_busy;
  assign err_event  = win_hit && !win_ok && !seq_busy;

  mrs_cmd_fsm #(
    .GAP_NOPS(GAP_NOPS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (seq_accept),
    .start_area(win_area),
    .start_cl  (win_cl),
    .state_q   (state_q),
    .area_q    (area_q),
    .cl_q      (cl_q),
    .seq_busy  (seq_busy),
    .seq_done  (seq_done)
  );

  mrs_pin_map #(
    .BUS32(BUS32)
  ) u_map (
    .cl       (cl_q),
    .mrs_pins (mrs_pins),
    .pall_pins(pall_pins)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_event;
  end

  always_comb begin
    drive_cmd = 1'b0;
    rcw       = RCW_NOP;
    pins      = '0;
    case (state_q)
      ST_PALL: begin drive_cmd = 1'b1; rcw = RCW_PALL; pins = pall_pins; end
      ST_GAP:  begin drive_cmd = 1'b1; rcw = RCW_NOP;  pins = '0;        end
      ST_MRS:  begin drive_cmd = 1'b1; rcw = RCW_MRS;  pins = mrs_pins;  end
      default: begin drive_cmd = 1'b0; rcw = RCW_NOP;  pins = '0;        end
    endcase
  end

  for (genvar a = 0; a < NUM_AREAS; a++) begin : g_cs
    assign cs_n_vec[a] = !(drive_cmd && (area_q == area_t'(a)));
  end

  assign sd_cs2_n = cs_n_vec[AREA_2];
  assign sd_cs3_n = cs_n_vec[AREA_3];
  assign sd_ras_n = rcw[2];
  assign sd_cas_n = rcw[1];
  assign sd_we_n  = rcw[0];
  assign sd_addr  = pins;

  assign cpu_wait = win_hit && seq_busy;
  assign mrs_busy = seq_busy;
  assign mrs_done = seq_done;
  assign mrs_err  = err_q;

endmodule

// File: rtl/sdram_mrs_seq_chk.sv
module sdram_mrs_seq_chk
  import sdram_mrs_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wait,
  input logic             mrs_busy,
  input logic             mrs_done,
  input logic             mrs_err,
  input logic             sd_cs2_n,
  input logic             sd_cs3_n,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic [PIN_W-1:0] sd_addr,
  input logic             seq_accept
);
  timeunit 1ns; timeprecision 1ps;

  logic       cs_act;
  logic [2:0] rcw;
  assign cs_act = !sd_cs2_n || !sd_cs3_n;
  assign rcw    = {sd_ras_n, sd_cas_n, sd_we_n};

  assert_one_area_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sd_cs2_n && !sd_cs3_n));

  assert_area_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs2_n && $past(cs_act)) |-> $past(!sd_cs2_n));

  assert_accept_pall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_accept |=> (cs_act && rcw == RCW_PALL));

  assert_pall_a10_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && rcw == RCW_PALL) |-> sd_addr[10]);

  assert_pall_then_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && rcw == RCW_PALL) |=> (cs_act && rcw == RCW_NOP));

  assert_mrs_after_nop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && rcw == RCW_MRS) |-> $past(cs_act && rcw == RCW_NOP));

  assert_mrs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && rcw == RCW_MRS) |=> (mrs_done && mrs_busy && !cs_act));

  assert_busy_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mrs_busy) |-> $past(mrs_done));

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mrs_err |-> (!cs_act && !mrs_busy));

  assert_wait_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> mrs_busy);

  assert_idle_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |-> (sd_addr == '0 && rcw == RCW_NOP));

endmodule

bind sdram_mrs_seq sdram_mrs_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_wait  (cpu_wait),
  .mrs_busy  (mrs_busy),
  .mrs_done  (mrs_done),
  .mrs_err   (mrs_err),
  .sd_cs2_n  (sd_cs2_n),
  .sd_cs3_n  (sd_cs3_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .seq_accept(seq_accept)
);

// File: tb/sdram_mrs_seq_tb.sv
module sdram_mrs_seq_tb;
  timeunit 1ns; timeprecision 1ps;

  localparam int GAP = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr32 = 1'b0;
  logic        wr16 = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = 2'b00;

  logic wait32, busy32, done32, err32, cs2_32, cs3_32, ras32, cas32, we32;
  logic wait16, busy16, done16, err16, cs2_16, cs3_16, ras16, cas16, we16;
  logic [15:0] a32, a16;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_mrs_seq #(.BUS32(1'b1), .GAP_NOPS(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(wr32), .cpu_addr(addr), .cpu_size(size),
    .cpu_wait(wait32), .mrs_busy(busy32), .mrs_done(done32), .mrs_err(err32),
    .sd_cs2_n(cs2_32), .sd_cs3_n(cs3_32), .sd_ras_n(ras32), .sd_cas_n(cas32),
    .sd_we_n(we32), .sd_addr(a32));

  sdram_mrs_seq #(.BUS32(1'b0), .GAP_NOPS(GAP)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(wr16), .cpu_addr(addr), .cpu_size(size),
    .cpu_wait(wait16), .mrs_busy(busy16), .mrs_done(done16), .mrs_err(err16),
    .sd_cs2_n(cs2_16), .sd_cs3_n(cs3_16), .sd_ras_n(ras16), .sd_cas_n(cas16),
    .sd_we_n(we16), .sd_addr(a16));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // {cs2, cs3, ras, cas, we}
  function automatic logic [4:0] obs(input bit d16);
    return d16 ? {cs2_16, cs3_16, ras16, cas16, we16} : {cs2_32, cs3_32, ras32, cas32, we32};
  endfunction
  function automatic logic [15:0] pins(input bit d16);
    return d16 ? a16 : a32;
  endfunction
  function automatic logic [3:0] flags(input bit d16);  // {busy, done, err, wait}
    return d16 ? {busy16, done16, err16, wait16} : {busy32, done32, err32, wait32};
  endfunction
  function automatic logic [4:0] exp_cmd(input bit a3, input logic [2:0] r);
    return a3 ? {2'b10, r} : {2'b01, r};
  endfunction
  function automatic logic [15:0] exp32(input int cl);
    return 16'(32'h800 | (cl << 6));
  endfunction
  function automatic logic [15:0] exp16(input int cl);
    return 16'(32'h400 | (cl << 5));
  endfunction
  function automatic logic [31:0] base(input bit a3);
    return a3 ? 32'hFFFF_E000 : 32'hFFFF_D000;
  endfunction

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic pulse_write(input bit d16, input logic [31:0] ad, input logic [1:0] sz);
    @(negedge clk);
    addr = ad; size = sz;
    if (d16) wr16 = 1'b1; else wr32 = 1'b1;
    tick();
    wr16 = 1'b0; wr32 = 1'b0;
    #0.1;
  endtask

  // Called in the cycle after acceptance (PALL cycle).
  task automatic follow_seq(input bit d16, input bit a3, input logic [15:0] exp_p, input string req_p);
    chk(obs(d16) == exp_cmd(a3, 3'b010), "R4", "PALL command", 32'(obs(d16)), 32'(exp_cmd(a3, 3'b010)));
    chk(pins(d16)[10] == 1'b1, "R4", "PALL A10", 32'(pins(d16)), 32'h400);
    chk(flags(d16)[3] == 1'b1, "R7", "busy during PALL", 32'(flags(d16)), 32'h8);
    for (int g = 0; g < GAP; g++) begin
      tick();
      chk(obs(d16) == exp_cmd(a3, 3'b111), "R4", "NOP gap", 32'(obs(d16)), 32'(exp_cmd(a3, 3'b111)));
    end
    tick();
    chk(obs(d16) == exp_cmd(a3, 3'b000), "R1", "MRS on addressed area only", 32'(obs(d16)), 32'(exp_cmd(a3, 3'b000)));
    chk(pins(d16) == exp_p, req_p, "MRS pin word", 32'(pins(d16)), 32'(exp_p));
    tick();
    chk(flags(d16)[3:2] == 2'b11 && obs(d16) == 5'b11111, "R7", "done cycle",
        32'({flags(d16), obs(d16)}), 32'({4'b1100, 5'b11111}));
    tick();
    chk(flags(d16) == 4'b0000 && obs(d16) == 5'b11111 && pins(d16) == 16'h0, "R9", "idle after sequence",
        32'({flags(d16), obs(d16)}), 32'({4'b0000, 5'b11111}));
  endtask

  task automatic t_reset();
    for (int d = 0; d < 2; d++) begin
      chk(obs(d[0]) == 5'b11111 && pins(d[0]) == 16'h0 && flags(d[0]) == 4'b0, "R9", "reset state",
          32'({flags(d[0]), obs(d[0]), pins(d[0])}), 32'({4'b0, 5'b11111, 16'h0}));
    end
  endtask

  task automatic t_bus32();
    for (int a3 = 0; a3 < 2; a3++)
      for (int cl = 1; cl <= 3; cl++) begin
        pulse_write(1'b0, base(a3[0]) + 32'(exp32(cl)), 2'b00);
        follow_seq(1'b0, a3[0], exp32(cl), "R2");
      end
  endtask

  task automatic t_bus16();
    for (int a3 = 0; a3 < 2; a3++)
      for (int cl = 1; cl <= 3; cl++) begin
        pulse_write(1'b1, base(a3[0]) + 32'(exp16(cl)), 2'b00);
        follow_seq(1'b1, a3[0], exp16(cl), "R3");
      end
  endtask

  task automatic t_ignored();
    logic [31:0] ads [4] = '{32'hFFFF_D840, 32'hFFFF_E840, 32'hFFFF_C840, 32'hFFFF_F840};
    logic [1:0]  szs [4] = '{2'b01, 2'b10, 2'b00, 2'b00};
    for (int i = 0; i < 4; i++) begin
      pulse_write(1'b0, ads[i], szs[i]);
      chk(flags(1'b0) == 4'b0 && obs(1'b0) == 5'b11111, "R5", "ignored write",
          32'({flags(1'b0), obs(1'b0)}), 32'({4'b0, 5'b11111}));
      tick();
      chk(flags(1'b0) == 4'b0 && obs(1'b0) == 5'b11111, "R5", "ignored write later",
          32'({flags(1'b0), obs(1'b0)}), 32'({4'b0, 5'b11111}));
    end
  endtask

  task automatic t_invalid();
    logic [11:0] o32 [6] = '{12'h800, 12'h900, 12'h844, 12'h860, 12'hA40, 12'h841};
    logic [11:0] o16 [5] = '{12'h840, 12'h400, 12'h480, 12'h422, 12'h430};
    for (int i = 0; i < 6; i++) begin
      pulse_write(1'b0, base(i[0]) + 32'(o32[i]), 2'b00);
      chk(flags(1'b0) == 4'b0010 && obs(1'b0) == 5'b11111, "R6", "bad offset 32-bit",
          32'({flags(1'b0), obs(1'b0)}), 32'({4'b0010, 5'b11111}));
      tick();
      chk(flags(1'b0) == 4'b0 && obs(1'b0) == 5'b11111, "R6", "error pulse one cycle",
          32'({flags(1'b0), obs(1'b0)}), 32'({4'b0, 5'b11111}));
    end
    for (int i = 0; i < 5; i++) begin
      pulse_write(1'b1, base(i[0]) + 32'(o16[i]), 2'b00);
      chk(flags(1'b1) == 4'b0010 && obs(1'b1) == 5'b11111, "R6", "bad offset 16-bit",
          32'({flags(1'b1), obs(1'b1)}), 32'({4'b0010, 5'b11111}));
      tick();
      chk(flags(1'b1) == 4'b0, "R6", "error pulse one cycle 16-bit", 32'(flags(1'b1)), 32'h0);
    end
  endtask

  task automatic t_contend();
    @(negedge clk);
    addr = base(1'b0) + 32'(exp32(1)); size = 2'b00; wr32 = 1'b1;
    tick();
    addr = base(1'b1) + 32'(exp32(3));
    #0.5;
    chk(obs(1'b0) == exp_cmd(1'b0, 3'b010), "R4", "first PALL under contention",
        32'(obs(1'b0)), 32'(exp_cmd(1'b0, 3'b010)));
    chk(wait32 == 1'b1, "R8", "wait in PALL", 32'(wait32), 32'h1);
    for (int g = 0; g < GAP; g++) begin
      tick();
      chk(wait32 == 1'b1, "R8", "wait in NOP", 32'(wait32), 32'h1);
    end
    tick();
    chk(obs(1'b0) == exp_cmd(1'b0, 3'b000) && a32 == exp32(1), "R8", "first MRS kept its value",
        32'({obs(1'b0), a32}), 32'({exp_cmd(1'b0, 3'b000), exp32(1)}));
    chk(wait32 == 1'b1, "R8", "wait in MRS", 32'(wait32), 32'h1);
    tick();
    chk(wait32 == 1'b1 && done32 == 1'b1, "R8", "wait in done cycle", 32'({wait32, done32}), 32'h3);
    tick();
    chk(wait32 == 1'b0 && busy32 == 1'b0 && obs(1'b0) == 5'b11111, "R8", "held write released",
        32'({wait32, busy32, obs(1'b0)}), 32'({2'b00, 5'b11111}));
    tick();
    wr32 = 1'b0;
    #0.1;
    follow_seq(1'b0, 1'b1, exp32(3), "R8");
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_bus32();
    t_bus16();
    t_ignored();
    t_invalid();
    t_contend();
    repeat (2) tick();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog: actual still running expected completion");
      finish_run();
    end
  end

endmodule